// File: doc/BRIEF.md
# Strip-Mined Shared Arithmetic Sequencer

This block runs a fixed dataflow kernel on a small shared array of pipelined integer units: one adder and one multiplier. There are fewer units than the kernel has operations. Iterations arrive as a stream of operand triples (a, b, c) and are grouped into strips of P consecutive iterations. Each unit's latency is padded to exactly P cycles. A whole strip therefore passes through one control step, one iteration per cycle, before the next step begins. A result issued for iteration slot i in one step appears at the unit output in slot i of the next step. A small schedule table gives the operand select codes of both units for each of the three compute steps. All P iterations of a strip share those codes.

Operand sources are the current inputs, recirculating input rings, each unit's output from the previous step, and a hold pipe for each unit that keeps the output from two steps back. The kernel computes s = a+b and m = a*c in step 0, t = s+m and u = s*c in step 1, and r0 = t+u and r1 = t*m in step 2. All arithmetic is modulo 2^W. The results leave during a drain step. In the normal mode the drain step is a separate P-cycle phase. In back-to-back mode the drain step overlaps step 0 of the next strip, which is possible because the drain step occupies no unit.

Input uses valid/ready: a triple is taken on a cycle where both in_valid and in_ready are high. in_ready is high only during step 0. While in_ready is high and in_valid is low, the whole sequencer freezes. The result port is a strobe with no back-pressure, since the strip timing is fixed. The consumer must take every beat on which out_valid is high.

Top module: `strip_reuse_seq`

## Requirements
- R1: During reset and on the first cycle after it, in_ready is 1 and out_valid is 0.
- R2: in_ready is 0 throughout compute steps 1 and 2 and the separate drain phase. A triple offered then is not taken and does not alter any result.
- R3: A strip takes exactly P triples. The step advances only after P slot advances, so in_ready stays high for exactly P accepting cycles per strip when input is continuous.
- R4: out_r0 equals (a+b) + a*c + (a+b)*c, modulo 2^W, for the iteration being reported.
- R5: out_r1 equals ((a+b) + a*c) * (a*c), modulo 2^W.
- R6: out_flag is 1 exactly when out_r0 > out_r1 as unsigned numbers.
- R7: Each accepted triple yields exactly one out_valid beat. Beats come in acceptance order, and nothing is left outstanding after the final strip drains.
- R8: A cycle in step 0 with in_valid low changes no state. The slot and step hold, the pipelines freeze, and in_ready stays 1.
- R9: With b2b_mode at 0, after step 2 there follows a P-cycle drain phase. In that phase out_valid is 1 and in_ready is 0, and step 0 comes after it.
- R10: With b2b_mode at 1, the results of a strip leave during the next strip's step 0. out_valid is high exactly on the cycles in which a new triple is taken, and there is no separate drain phase.
- R11: With continuous input in the normal mode, the first result of a strip appears exactly 3*P cycles after its first triple is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| b2b_mode | input | 1 | 1: overlap the drain with the next strip; sampled at the end of step 2 |
| in_valid | input | 1 | Operand triple is present |
| in_ready | output | 1 | Sequencer takes a triple this cycle (step 0) |
| in_a | input | W | Operand a |
| in_b | input | W | Operand b |
| in_c | input | W | Operand c |
| out_valid | output | 1 | Result strobe, one beat per iteration |
| out_r0 | output | W | First kernel result |
| out_r1 | output | W | Second kernel result |
| out_flag | output | 1 | Compare flag, r0 > r1 |

## Verification
A wrong slot or step count shows at once on the handshake pins. in_ready opens or closes one cycle off its expected window, and out_valid appears in a step where the cycle model expects silence. Both are caught on the very cycle they diverge. A misaligned pipeline, a wrong schedule entry or a ring that fails to recirculate leaves the handshake intact. It corrupts out_r0 and out_r1 on the first drain beat of the affected strip, about 3*P cycles after the bad input was taken. A stall that leaks into state shows up as a shifted result order within the same strip.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // number of compute steps in the kernel schedule; step N_STEPS is the drain step
  localparam int N_STEPS = 3;

  typedef enum logic [2:0] {
    SRC_IN0  = 3'd0,
    SRC_IN1  = 3'd1,
    SRC_IN2  = 3'd2,
    SRC_ADD  = 3'd3,
    SRC_MUL  = 3'd4,
    SRC_ADDH = 3'd5,
    SRC_MULH = 3'd6,
    SRC_ZERO = 3'd7
  } src_e;

  typedef struct packed {
    src_e add_a;
    src_e add_b;
    src_e mul_a;
    src_e mul_b;
  } ctl_t;
endpackage

// File: rtl/sched_rom.sv
module sched_rom
  import seq_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  logic [STEP_W-1:0] step,
  output ctl_t              ctl
);
  // step 0: s=a+b, m=a*c | step 1: t=s+m, u=s*c | step 2: r0=t+u, r1=t*m(held)
  always_comb begin
    ctl = '{add_a: SRC_ZERO, add_b: SRC_ZERO, mul_a: SRC_ZERO, mul_b: SRC_ZERO};
    case (step)
      STEP_W'(0): ctl = '{add_a: SRC_IN0, add_b: SRC_IN1, mul_a: SRC_IN0, mul_b: SRC_IN2};
      STEP_W'(1): ctl = '{add_a: SRC_ADD, add_b: SRC_MUL, mul_a: SRC_ADD, mul_b: SRC_IN2};
      STEP_W'(2): ctl = '{add_a: SRC_ADD, add_b: SRC_MUL, mul_a: SRC_ADD, mul_b: SRC_MULH};
      default:    ctl = '{add_a: SRC_ZERO, add_b: SRC_ZERO, mul_a: SRC_ZERO, mul_b: SRC_ZERO};
    endcase
  end
endmodule

// File: rtl/delay_pipe.sv
module delay_pipe #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)  stage_q[g] <= '0;
      else if (en) stage_q[g] <= (g == 0) ? d : stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stage_q[DEPTH-1];

  // a frozen strip must not slip: no shift without enable
  assert_pipe_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/op_unit.sv
module op_unit #(
  parameter int W      = 16,
  parameter int P      = 4,
  parameter bit IS_MUL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  logic [W-1:0] raw;

  if (IS_MUL) begin : g_mul
    assign raw = opa * opb;
  end else begin : g_add
    assign raw = opa + opb;
  end

  // latency padded to exactly P so one strip spans one step
  delay_pipe #(.W(W), .DEPTH(P)) u_pad (
    .clk(clk), .rst_n(rst_n), .en(en), .d(raw), .q(res)
  );
endmodule

// File: rtl/strip_reuse_seq.sv
module strip_reuse_seq
  import seq_pkg::*;
#(
  parameter int W = 16,
  parameter int P = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         b2b_mode,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic         out_valid,
  output logic [W-1:0] out_r0,
  output logic [W-1:0] out_r1,
  output logic         out_flag
);
  localparam int SLOT_W = (P > 1) ? $clog2(P) : 1;
  localparam int STEP_W = $clog2(N_STEPS + 1);
  localparam int N_IN   = 3;

  logic [SLOT_W-1:0] slot_q;
  logic [STEP_W-1:0] step_q;
  logic              drn_q;
  logic              first, drain, adv, last_slot;
  ctl_t              ctl;

  assign first     = (step_q == STEP_W'(0));
  assign drain     = (step_q == STEP_W'(N_STEPS));
  assign last_slot = (slot_q == SLOT_W'(P-1));
  assign adv       = first ? in_valid : 1'b1;
  assign in_ready  = first;
  assign out_valid = drain || (first && drn_q && in_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      step_q <= '0;
      drn_q  <= 1'b0;
    end else if (adv) begin
      if (last_slot) begin
        slot_q <= '0;
        if (drain) begin
          step_q <= '0;
          drn_q  <= 1'b0;
        end else if (step_q == STEP_W'(N_STEPS-1)) begin
          step_q <= b2b_mode ? STEP_W'(0) : STEP_W'(N_STEPS);
          drn_q  <= b2b_mode;
        end else begin
          step_q <= step_q + 1'b1;
          drn_q  <= 1'b0;
        end
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  sched_rom #(.STEP_W(STEP_W)) u_rom (.step(step_q), .ctl(ctl));

  // input rings: load during step 0, recirculate otherwise
  logic [W-1:0] in_bus [N_IN];
  logic [W-1:0] ring_q [N_IN];
  logic [W-1:0] cur    [N_IN];
  assign in_bus[0] = in_a;
  assign in_bus[1] = in_b;
  assign in_bus[2] = in_c;

  for (genvar k = 0; k < N_IN; k++) begin : g_ring
    assign cur[k] = first ? in_bus[k] : ring_q[k];
    delay_pipe #(.W(W), .DEPTH(P)) u_ring (
      .clk(clk), .rst_n(rst_n), .en(adv), .d(cur[k]), .q(ring_q[k])
    );
  end

  logic [W-1:0] add_q, mul_q, addh_q, mulh_q;

  function automatic logic [W-1:0] pick(input src_e s, input logic [W-1:0] i0, i1, i2,
                                        input logic [W-1:0] ad, mu, adh, muh);
    case (s)
      SRC_IN0:  return i0;
      SRC_IN1:  return i1;
      SRC_IN2:  return i2;
      SRC_ADD:  return ad;
      SRC_MUL:  return mu;
      SRC_ADDH: return adh;
      SRC_MULH: return muh;
      default:  return '0;
    endcase
  endfunction

  logic [W-1:0] add_a, add_b, mul_a, mul_b;
  assign add_a = pick(ctl.add_a, cur[0], cur[1], cur[2], add_q, mul_q, addh_q, mulh_q);
  assign add_b = pick(ctl.add_b, cur[0], cur[1], cur[2], add_q, mul_q, addh_q, mulh_q);
  assign mul_a = pick(ctl.mul_a, cur[0], cur[1], cur[2], add_q, mul_q, addh_q, mulh_q);
  assign mul_b = pick(ctl.mul_b, cur[0], cur[1], cur[2], add_q, mul_q, addh_q, mulh_q);

  op_unit #(.W(W), .P(P), .IS_MUL(1'b0)) u_add (
    .clk(clk), .rst_n(rst_n), .en(adv), .opa(add_a), .opb(add_b), .res(add_q)
  );
  op_unit #(.W(W), .P(P), .IS_MUL(1'b1)) u_mul (
    .clk(clk), .rst_n(rst_n), .en(adv), .opa(mul_a), .opb(mul_b), .res(mul_q)
  );

  // chained hold pipes: each unit's value from two steps back
  delay_pipe #(.W(W), .DEPTH(P)) u_addh (
    .clk(clk), .rst_n(rst_n), .en(adv), .d(add_q), .q(addh_q)
  );
  delay_pipe #(.W(W), .DEPTH(P)) u_mulh (
    .clk(clk), .rst_n(rst_n), .en(adv), .d(mul_q), .q(mulh_q)
  );

  assign out_r0   = add_q;
  assign out_r1   = mul_q;
  assign out_flag = add_q > mul_q;

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SLOT_W'(P-1));

  assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !last_slot) |=> $stable(step_q));

  assert_stall_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(slot_q) && $stable(step_q) && in_ready));

  assert_result_without_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |-> !in_ready);
endmodule

// File: tb/strip_reuse_seq_bench.sv
module strip_reuse_seq_bench;
  localparam int W  = 16;
  localparam int P  = 4;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, b2b_mode, in_valid, in_ready, out_valid, out_flag;
  logic [W-1:0] in_a, in_b, in_c, out_r0, out_r1;

  strip_reuse_seq #(.W(W), .P(P)) u_strip_reuse_seq (
    .clk(clk), .rst_n(rst_n), .b2b_mode(b2b_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_r0(out_r0), .out_r1(out_r1), .out_flag(out_flag)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  int mstep = 0, mslot = 0;
  bit mdrn = 1'b0;
  bit mode = 1'b0;
  logic [W-1:0] da, db, dc;
  logic [W-1:0] q0[$], q1[$];
  bit qf[$];

  function automatic logic [W-1:0] ref_r0(logic [W-1:0] a, b, c);
    logic [W-1:0] s, m;
    s = a + b; m = a * c;
    return s + m + s * c;
  endfunction

  function automatic logic [W-1:0] ref_r1(logic [W-1:0] a, b, c);
    logic [W-1:0] s, m, t;
    s = a + b; m = a * c; t = s + m;
    return t * m;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic rnd();
    da = W'($urandom); db = W'($urandom); dc = W'($urandom);
  endtask

  // one clock of stimulus plus the cycle-level reference comparison
  task automatic cyc(bit v);
    bit exp_rdy, exp_ov, adv;
    string tag;
    logic [W-1:0] e0, e1;
    bit ef;
    @(negedge clk);
    in_valid = v; in_a = da; in_b = db; in_c = dc; b2b_mode = mode;
    #1;
    exp_rdy = (mstep == 0);
    tag = (mstep == 0) ? (v ? "R3" : "R8") : "R2";
    chk(in_ready == exp_rdy, tag, "in_ready", in_ready, exp_rdy);
    exp_ov = (mstep == NS) || (mstep == 0 && mdrn && v);
    tag = (mstep == 0) ? "R10" : ((mslot == 0) ? "R11" : "R9");
    chk(out_valid == exp_ov, tag, "out_valid", out_valid, exp_ov);
    if (exp_ov && out_valid) begin
      if (q0.size() == 0) chk(1'b0, "R7", "unexpected result beat", 1, 0);
      else begin
        e0 = q0.pop_front(); e1 = q1.pop_front(); ef = qf.pop_front();
        chk(out_r0 == e0, "R4", "out_r0", out_r0, e0);
        chk(out_r1 == e1, "R5", "out_r1", out_r1, e1);
        chk(out_flag == ef, "R6", "out_flag", out_flag, ef);
      end
    end
    if (v && exp_rdy) begin
      e0 = ref_r0(da, db, dc); e1 = ref_r1(da, db, dc);
      q0.push_back(e0); q1.push_back(e1); qf.push_back(e0 > e1);
    end
    adv = (mstep == 0) ? v : 1'b1;
    if (adv) begin
      mslot++;
      if (mslot == P) begin
        mslot = 0;
        if (mstep == NS) begin mstep = 0; mdrn = 0; end
        else if (mstep == NS-1) begin mstep = mode ? 0 : NS; mdrn = mode; end
        else begin mstep++; mdrn = 0; end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; b2b_mode = 1'b0; in_valid = 1'b0;
    in_a = '0; in_b = '0; in_c = '0; da = '0; db = '0; dc = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // normal mode, continuous input (R11 latency, R9 drain phase)
    for (int i = 0; i < 3 * P * (NS + 1); i++) begin rnd(); cyc(1'b1); end
    // normal mode with gaps (R8 stalls, R2 refused offers)
    for (int i = 0; i < 300; i++) begin rnd(); cyc(($urandom % 3) != 0); end
    // boundary operand values (R4, R5, R6)
    for (int i = 0; i < 8; i++) begin
      da = i[0] ? '1 : '0; db = i[1] ? '1 : '0; dc = i[2] ? '1 : W'(1);
      cyc(1'b1);
    end
    // switch to back-to-back mode inside step 1
    while (mstep != 1) begin rnd(); cyc(1'b1); end
    mode = 1'b1;
    for (int i = 0; i < 80; i++) begin rnd(); cyc(1'b1); end
    for (int i = 0; i < 300; i++) begin rnd(); cyc(($urandom % 4) != 0); end
    // back to normal mode and flush (R7)
    while (mstep != 1) begin rnd(); cyc(1'b1); end
    mode = 1'b0;
    while (!(mstep == 0 && !mdrn)) begin rnd(); cyc(1'b1); end
    for (int i = 0; i < 5; i++) begin rnd(); cyc(1'b0); end
    chk(q0.size() == 0, "R7", "results left outstanding", q0.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule